// File: doc/BRIEF.md
# AC-link Power Sequencing Timer

This block handles the slow power-state signalling of an AC97 audio link from the fast host bus clock. A free-running prescaler divides the host clock into a single-cycle tick with a nominal 250 ns period. Every link duration is counted in these ticks, so retargeting to another host frequency means changing only the prescaler terminal value.

Two timed sequences share the tick. A cold reset drives the codec reset line low for a fixed number of ticks. A resume drives the sync line high for a fixed number of ticks. The resume count carries one spare tick, because the first tick after a request may fall in the very next cycle. Either sequence starts from a one-cycle request, so a short request is stretched to the full length. Only one sequence runs at a time. A completion strobe marks the cycle in which the driven line is released.

Separately, the incoming bit clock is resynchronised into the host domain. The block counts host cycles that pass with no edge on it. When the count reaches a threshold, the link is flagged as suspended, and the flag holds until the clock moves again.

Top module: `aclink_pwr_seq`

## Requirements
- R1: After host reset the outputs are codec_rst_n=1, sync_force=0, busy=0, done=0 and link_suspended=0.
- R2: A one-cycle cold_req seen while idle drives codec_rst_n low from the next cycle. The low time is between (RST_TICKS-1)*P+1 and RST_TICKS*P host cycles, where P=TICK_LAST+1. With the defaults this is 151 to 200 cycles.
- R3: A one-cycle wake_req seen while idle drives sync_force high from the next cycle. The high time is between (WAKE_TICKS-1)*P+1 and WAKE_TICKS*P host cycles. With the defaults this is 201 to 250 cycles, which is at least 1 us at a 200 MHz host clock.
- R4: busy is 1 in exactly the cycles in which codec_rst_n is low or sync_force is high. done is a one-cycle pulse in the first cycle after the driven line is released, and at that point busy is already 0.
- R5: A cold_req or wake_req that arrives while busy=1 is ignored. The running pulse is not lengthened, and no second pulse follows.
- R6: If cold_req and wake_req are both 1 in the same idle cycle, only the cold reset runs and the resume request is dropped.
- R7: link_suspended rises once the bit clock has shown no edge for SUSP_CYCLES host cycles after the SYNC_STAGES-flop synchroniser. With the defaults, it is 0 thirty cycles after the last input change and 1 forty cycles after. It stays 1 for as long as the clock stays still, because the counter saturates.
- R8: Any rising or falling edge on bit_clk clears link_suspended within SYNC_STAGES+1 host cycles. A bit clock that toggles every 30 host cycles never sets it, while one that toggles every 40 host cycles does.
- R9: The two sequences and the suspend detector are independent. A resume that runs while the link is suspended keeps its full length, even if the bit clock restarts partway through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| host_rst_n | input | 1 | Host reset, active low, synchronous |
| cold_req | input | 1 | Request to start a codec cold reset |
| wake_req | input | 1 | Request to start resume signalling |
| bit_clk | input | 1 | Link bit clock, asynchronous to clk |
| codec_rst_n | output | 1 | Codec reset, active low |
| sync_force | output | 1 | Holds the sync line high during resume |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |
| link_suspended | output | 1 | Bit clock judged absent |

## Verification
The resume sequence and the suspend detector can act in the same cycles. The bench provokes this by stopping the bit clock until link_suspended rises, then issuing a resume, and then restarting the bit clock while sync_force is still high. It checks that the suspended flag clears within the synchroniser delay and that the resume pulse, measured by the scoreboard monitor, still falls inside its full tick window. Simultaneous cold and resume requests, and requests made during a running pulse, are judged the same way: any pulse the scoreboard did not expect counts as a miscompare.

// File: rtl/aclink_pwr_pkg.sv
package aclink_pwr_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_COLD = 2'd1,
      SEQ_WAKE = 2'd2
   } seq_state_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/aclink_tick_gen.sv
module aclink_tick_gen #(
   parameter int TICK_LAST = 49
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   initial assert (TICK_LAST >= 0) else $error("TICK_LAST must not be negative");

   generate
      if (TICK_LAST == 0) begin : g_every_cycle
         assign tick_o = rst_n;
      end else begin : g_counter
         localparam int PW = $clog2(TICK_LAST + 1);
         localparam logic [PW-1:0] LAST = PW'(TICK_LAST);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n)           pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                  pre_q <= pre_q + 1'b1;
         end

         assign tick_o = (pre_q == LAST);

         // R2
         tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate

endmodule

// File: rtl/aclink_seq.sv
module aclink_seq
   import aclink_pwr_pkg::*;
#(
   parameter int RST_TICKS  = 4,
   parameter int WAKE_TICKS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic cold_req_i,
   input  logic wake_req_i,
   output logic codec_rst_n_o,
   output logic sync_force_o,
   output logic busy_o,
   output logic done_o
);

   localparam int MAXT = max_int(RST_TICKS, WAKE_TICKS);
   localparam int TW   = $clog2(MAXT + 1);
   localparam logic [TW-1:0] RST_LAST  = TW'(RST_TICKS - 1);
   localparam logic [TW-1:0] WAKE_LAST = TW'(WAKE_TICKS - 1);

   initial assert (RST_TICKS >= 1)  else $error("RST_TICKS must be at least 1");
   initial assert (WAKE_TICKS >= 2) else $error("WAKE_TICKS needs a spare tick");

   seq_state_t    state_q;
   logic [TW-1:0] tcnt_q;
   logic          done_q;
   logic          last_w;

   always_comb begin
      if (state_q == SEQ_COLD) last_w = (tcnt_q == RST_LAST);
      else                     last_w = (tcnt_q == WAKE_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         tcnt_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               tcnt_q <= '0;
               if (cold_req_i)      state_q <= SEQ_COLD;
               else if (wake_req_i) state_q <= SEQ_WAKE;
            end
            default: begin
               if (tick_i) begin
                  if (last_w) begin
                     state_q <= SEQ_IDLE;
                     tcnt_q  <= '0;
                     done_q  <= 1'b1;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign codec_rst_n_o = (state_q != SEQ_COLD);
   assign sync_force_o  = (state_q == SEQ_WAKE);
   assign busy_o        = (state_q != SEQ_IDLE);
   assign done_o        = done_q;

   // R5
   mid_seq_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(codec_rst_n_o) && $stable(sync_force_o)));

   // R4
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R2
   end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(tick_i));

endmodule

// File: rtl/aclink_clk_loss_det.sv
module aclink_clk_loss_det #(
   parameter int SUSP_CYCLES = 33,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_clk_i,
   output logic susp_o
);

   localparam int SW = $clog2(SUSP_CYCLES + 1);
   localparam logic [SW-1:0] THR = SW'(SUSP_CYCLES);

   initial assert (SUSP_CYCLES >= 1) else $error("SUSP_CYCLES must be at least 1");
   initial assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [SW-1:0]          idle_q;
   logic                   edge_w;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= bit_clk_i;
   end

   generate
      for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign edge_w = sync_q[SYNC_STAGES-1] ^ prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            idle_q <= '0;
      else if (edge_w)       idle_q <= '0;
      else if (idle_q != THR) idle_q <= idle_q + 1'b1;
   end

   assign susp_o = (idle_q == THR);

   // R7
   susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_o && !edge_w) |=> susp_o);

   // R8
   susp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_w |=> !susp_o);

endmodule

// File: rtl/aclink_pwr_seq.sv
module aclink_pwr_seq #(
   parameter int TICK_LAST   = 49,
   parameter int RST_TICKS   = 4,
   parameter int WAKE_TICKS  = 5,
   parameter int SUSP_CYCLES = 33,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic host_rst_n,
   input  logic cold_req,
   input  logic wake_req,
   input  logic bit_clk,
   output logic codec_rst_n,
   output logic sync_force,
   output logic busy,
   output logic done,
   output logic link_suspended
);

   logic tick_w;

   aclink_tick_gen #(
      .TICK_LAST (TICK_LAST)
   ) tick_i (
      .clk    (clk),
      .rst_n  (host_rst_n),
      .tick_o (tick_w)
   );

   aclink_seq #(
      .RST_TICKS  (RST_TICKS),
      .WAKE_TICKS (WAKE_TICKS)
   ) seq_i (
      .clk           (clk),
      .rst_n         (host_rst_n),
      .tick_i        (tick_w),
      .cold_req_i    (cold_req),
      .wake_req_i    (wake_req),
      .codec_rst_n_o (codec_rst_n),
      .sync_force_o  (sync_force),
      .busy_o        (busy),
      .done_o        (done)
   );

   aclink_clk_loss_det #(
      .SUSP_CYCLES (SUSP_CYCLES),
      .SYNC_STAGES (SYNC_STAGES)
   ) det_i (
      .clk       (clk),
      .rst_n     (host_rst_n),
      .bit_clk_i (bit_clk),
      .susp_o    (link_suspended)
   );

   // R6
   single_mode_chk: assert property (@(posedge clk) disable iff (!host_rst_n)
      !(!codec_rst_n && sync_force));

endmodule

// File: tb/aclink_pwr_seq_tb_top.sv
module aclink_pwr_seq_tb_top;

   localparam int TICK_LAST  = 49;
   localparam int RST_TICKS  = 4;
   localparam int WAKE_TICKS = 5;
   localparam int P          = TICK_LAST + 1;

   typedef struct {
      int kind;   // 0 cold, 1 wake
      int lo;
      int hi;
   } exp_t;

   logic clk = 1'b0;
   logic host_rst_n = 1'b0;
   logic cold_req = 1'b0;
   logic wake_req = 1'b0;
   logic bit_clk = 1'b0;
   logic codec_rst_n, sync_force, busy, done, link_suspended;

   int   n_chk  = 0;
   int   n_fail = 0;
   int   bc_half = 3;
   bit   finished = 1'b0;
   exp_t sb_q[$];
   int   cold_len = 0;
   int   wake_len = 0;

   always #10 clk = ~clk;

   aclink_pwr_seq #(
      .TICK_LAST  (TICK_LAST),
      .RST_TICKS  (RST_TICKS),
      .WAKE_TICKS (WAKE_TICKS)
   ) dut_i (
      .clk            (clk),
      .host_rst_n     (host_rst_n),
      .cold_req       (cold_req),
      .wake_req       (wake_req),
      .bit_clk        (bit_clk),
      .codec_rst_n    (codec_rst_n),
      .sync_force     (sync_force),
      .busy           (busy),
      .done           (done),
      .link_suspended (link_suspended)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   // bit clock generator
   initial begin
      forever begin
         if (bc_half > 0) begin
            repeat (bc_half) @(negedge clk);
            if (bc_half > 0) bit_clk = ~bit_clk;
         end else begin
            @(negedge clk);
         end
      end
   end

   // scoreboard monitor
   task automatic close_pulse(input int kind, input int len);
      exp_t e;
      if (sb_q.size() == 0) begin
         chk(1'b0, "R5 unexpected pulse", len, 0);
         return;
      end
      e = sb_q.pop_front();
      chk(e.kind == kind, "R6 pulse kind", kind, e.kind);
      n_chk++;
      if (len < e.lo || len > e.hi) begin
         n_fail++;
         $display("FAIL %s width actual %0d expected %0d..%0d",
                  (kind == 0) ? "R2" : "R3", len, e.lo, e.hi);
      end
      chk(done == 1'b1, "R4 done at release", int'(done), 1);
      chk(busy == 1'b0, "R4 busy at release", int'(busy), 0);
   endtask

   always @(negedge clk) begin
      if (host_rst_n) begin
         if (!codec_rst_n) cold_len++;
         else if (cold_len != 0) begin close_pulse(0, cold_len); cold_len = 0; end
         if (sync_force) wake_len++;
         else if (wake_len != 0) begin close_pulse(1, wake_len); wake_len = 0; end
      end
   end

   // driver
   task automatic issue(input bit c, input bit w, input bit expect_pulse);
      exp_t e;
      @(negedge clk);
      cold_req = c;
      wake_req = w;
      if (expect_pulse) begin
         e.kind = c ? 0 : 1;
         e.lo   = c ? (RST_TICKS - 1) * P + 1 : (WAKE_TICKS - 1) * P + 1;
         e.hi   = c ? RST_TICKS * P : WAKE_TICKS * P;
         sb_q.push_back(e);
      end
      @(negedge clk);
      cold_req = 1'b0;
      wake_req = 1'b0;
      if (expect_pulse) chk(busy == 1'b1, "R4 busy after request", int'(busy), 1);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy);
      repeat (3) @(negedge clk);
   endtask

   task automatic restart_bc(input int half);
      @(negedge clk);
      bit_clk = ~bit_clk;
      bc_half = half;
   endtask

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      host_rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(codec_rst_n == 1'b1, "R1 codec_rst_n", int'(codec_rst_n), 1);
      chk(sync_force == 1'b0, "R1 sync_force", int'(sync_force), 0);
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(link_suspended == 1'b0, "R1 suspended", int'(link_suspended), 0);

      // R2 and R3 basic pulses
      issue(1'b1, 1'b0, 1'b1);
      wait_idle();
      issue(1'b0, 1'b1, 1'b1);
      wait_idle();

      // R2 cold pulses at several prescaler phases
      for (int k = 0; k < 5; k++) begin
         repeat (k * 11) @(negedge clk);
         issue(1'b1, 1'b0, 1'b1);
         wait_idle();
      end
      // R3 resume at several phases
      for (int k = 0; k < 3; k++) begin
         repeat (k * 17 + 1) @(negedge clk);
         issue(1'b0, 1'b1, 1'b1);
         wait_idle();
      end

      // R5 requests during running sequences are ignored
      issue(1'b1, 1'b0, 1'b1);
      repeat (60) @(negedge clk);
      issue(1'b1, 1'b1, 1'b0);
      repeat (60) @(negedge clk);
      issue(1'b0, 1'b1, 1'b0);
      wait_idle();
      repeat (300) @(negedge clk);
      chk(sb_q.size() == 0, "R5 queue drained", sb_q.size(), 0);
      chk(codec_rst_n == 1'b1 && sync_force == 1'b0, "R5 no extra pulse",
          int'(sync_force), 0);

      // R6 simultaneous requests: cold wins
      issue(1'b1, 1'b1, 1'b1);
      wait_idle();
      repeat (300) @(negedge clk);
      chk(sb_q.size() == 0, "R6 resume dropped", sb_q.size(), 0);

      // R7 suspend detection and saturation
      bc_half = 0;
      repeat (30) @(negedge clk);
      chk(link_suspended == 1'b0, "R7 not yet suspended", int'(link_suspended), 0);
      repeat (10) @(negedge clk);
      chk(link_suspended == 1'b1, "R7 suspended", int'(link_suspended), 1);
      repeat (200) @(negedge clk);
      chk(link_suspended == 1'b1, "R7 held while absent", int'(link_suspended), 1);

      // R8 edge clears the flag
      restart_bc(3);
      repeat (3) @(negedge clk);
      chk(link_suspended == 1'b0, "R8 cleared by edge", int'(link_suspended), 0);

      // R8 slow clock, half period 30: never suspended
      bc_half = 30;
      repeat (5) @(negedge clk);
      seen = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (link_suspended) seen++;
      end
      chk(seen == 0, "R8 half period 30 never flags", seen, 0);

      // R8 slower clock, half period 40: flags
      bc_half = 40;
      seen = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (link_suspended) seen++;
      end
      chk(seen > 0, "R8 half period 40 flags", seen, 1);

      // R9 resume while suspended, clock restarts mid-pulse
      bc_half = 0;
      repeat (60) @(negedge clk);
      chk(link_suspended == 1'b1, "R9 suspended before resume", int'(link_suspended), 1);
      issue(1'b0, 1'b1, 1'b1);
      repeat (100) @(negedge clk);
      chk(link_suspended == 1'b1 && sync_force == 1'b1, "R9 both active",
          int'(sync_force), 1);
      restart_bc(3);
      repeat (3) @(negedge clk);
      chk(link_suspended == 1'b0, "R9 flag clears mid-pulse", int'(link_suspended), 0);
      chk(sync_force == 1'b1, "R9 pulse continues", int'(sync_force), 1);
      wait_idle();
      chk(sb_q.size() == 0, "R9 pulse completed", sb_q.size(), 0);

      finish_run();
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual %0d expected %0d", 150000, 0);
      finish_run();
   end

endmodule